// File: doc/BRIEF.md
# Edge-Qualified Interrupt Request Recognizer

This block receives two asynchronous interrupt request lines: a non-maskable request that is active high and a system-management request that is active low. Each line goes through its own synchronizer. A per-source qualifier then accepts a transition only when the line was quiet long enough before it and, where this is required, stays active long enough after it. Each accepted transition sets a pending flag.

The core raises a one-cycle instruction-boundary strobe when it can accept an interrupt. During that strobe the block reports which pending request is taken. The system-management request always wins over the non-maskable request. A pending flag stays set until the core acknowledges it. A request that arrives while the same source is already pending is absorbed into the existing flag and is not counted again.

Top module: `irq_edge_recognizer`

## Requirements
- R1: Each raw input passes through a two-flop synchronizer. A qualifying non-maskable rise is driven before clock edge k, and `nmi_pending` becomes 1 after edge k+2. It is still 0 after edge k+1.
- R2: A non-maskable rising edge counts only if the synchronized input was low for at least 4 consecutive clocks just before the edge. A rise that follows 3 or fewer low clocks is discarded.
- R3: A non-maskable line that stays high produces exactly one request. The high level never causes a new request.
- R4: A system-management falling edge counts when the line was high for at least 2 clocks before it and stays low for at least 2 clocks. A fall driven before edge k sets `smi_pending` after edge k+3. It is still 0 after edge k+2.
- R5: A system-management low pulse shorter than 2 clocks is discarded. A fall that follows fewer than 2 high clocks is also discarded.
- R6: A pending flag stays 1 until its acknowledge input is sampled high at a clock edge, and then it becomes 0. Being taken does not clear it. If a new qualifying request arrives in the same cycle as the acknowledge, the flag stays set.
- R7: A second qualifying request that arrives while its flag is still pending merges into that flag. One acknowledge then leaves the flag at 0.
- R8: `nmi_taken` and `smi_taken` can be 1 only while `insn_boundary` is 1. The taken outputs are combinational, so they follow the strobe within the same cycle.
- R9: When both flags are pending at a boundary, only `smi_taken` is asserted. The non-maskable request stays pending and is taken at a later boundary.
- R10: The synchronous active-low reset clears both pending flags, the synchronizers and all qualification state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi_raw | input | 1 | Asynchronous non-maskable request, active high |
| smi_raw_n | input | 1 | Asynchronous system-management request, active low |
| insn_boundary | input | 1 | One-cycle strobe marking an instruction boundary |
| nmi_ack | input | 1 | Clears the non-maskable pending flag |
| smi_ack | input | 1 | Clears the system-management pending flag |
| nmi_pending | output | 1 | Non-maskable request waiting |
| smi_pending | output | 1 | System-management request waiting |
| nmi_taken | output | 1 | Non-maskable request taken at this boundary |
| smi_taken | output | 1 | System-management request taken at this boundary |

## Verification
The bench targets the exact quiet-time thresholds of both sources:
- A non-maskable rise after 3 low clocks must be rejected and one after 4 low clocks accepted. An off-by-one in the quiet counter shows up as a missing or spurious pending flag.
- A system-management low pulse of one cycle must be ignored. So must a fall that follows a single high cycle. A qualifier that skipped the hold check or the quiet check would raise a request for either.

Three further checks cover the pending flags and the taken outputs:
- The bench holds the non-maskable line high after an acknowledge. It issues a second edge while the flag is still pending. A level-triggered design or a queueing design would show a request that comes back.
- Simultaneous requests must give the system-management source the boundary and leave the non-maskable request pending. Otherwise the priority is reversed or a request is lost.
- Exact latency sampling catches a synchronizer with a missing or extra stage.

// File: rtl/irq_rec_pkg.sv
// Package: shared types for the interrupt request recognizer.
// Assumes: exactly two request sources, the system-management one first in priority.
package irq_rec_pkg;

    // Which level of a raw line counts as asserted.
    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } irq_pol_e;

    // One bit per request source.
    typedef struct packed {
        logic smi;
        logic nmi;
    } irq_pair_t;

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Carries one asynchronous level into the clk domain through a chain of flops.
// Assumes: STAGES >= 2. RST_VAL is the inactive level of the line, so reset never
// produces a false edge downstream.
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw line.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Later stage: shift the previous stage forward.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/irq_edge_qual.sv
// Module: irq_edge_qual
// Turns a synchronized request line into a single-cycle fire pulse when an
// asserting edge meets the quiet-time and hold-time limits.
// Quiet: the line was inactive for at least QUIET clocks right before the edge.
// Hold: the line is active for HOLD consecutive clocks, counting the edge cycle.
//   fire is raised in the last of those cycles.
// Assumes: QUIET >= 1, HOLD >= 1, and sync_in is already in the clk domain.
// Both counters saturate.
module irq_edge_qual
    import irq_rec_pkg::*;
#(
    parameter irq_pol_e POLARITY = POL_HIGH,
    parameter int       QUIET    = 4,
    parameter int       HOLD     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic fire
);

    localparam int            QW      = $clog2(QUIET + 1);
    localparam logic [QW-1:0] QUIET_C = QW'(QUIET);

    logic          act;
    logic          act_q;
    logic          rise;
    logic          quiet_ok;
    logic [QW-1:0] quiet_cnt;

    // Normalize to active-high.
    assign act      = (POLARITY == POL_LOW) ? ~sync_in : sync_in;
    assign rise     = act & ~act_q;
    assign quiet_ok = (quiet_cnt >= QUIET_C);

    // Remember the previous active state to find the asserting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // Count consecutive inactive clocks, saturating at QUIET.
    always_ff @(posedge clk) begin
        if (!rst_n)                 quiet_cnt <= '0;
        else if (act)               quiet_cnt <= '0;
        else if (quiet_cnt != QUIET_C) quiet_cnt <= quiet_cnt + 1'b1;
    end

    generate
        if (HOLD <= 1) begin : g_no_hold
            // No hold check: the edge itself decides.
            assign fire = rise & quiet_ok;
        end else begin : g_hold
            localparam int            HW      = $clog2(HOLD + 1);
            localparam logic [HW-1:0] HOLD_C  = HW'(HOLD);
            localparam logic [HW-1:0] HOLD_M1 = HW'(HOLD - 1);

            logic          armed;
            logic          eligible;
            logic [HW-1:0] hold_cnt;

            assign eligible = rise ? quiet_ok : armed;
            assign fire     = act & eligible & (hold_cnt == HOLD_M1);

            // Keep the edge's quiet verdict for as long as the line stays active.
            always_ff @(posedge clk) begin
                if (!rst_n)   armed <= 1'b0;
                else if (act) armed <= eligible;
                else          armed <= 1'b0;
            end

            // Count consecutive active clocks, saturating at HOLD.
            always_ff @(posedge clk) begin
                if (!rst_n)                 hold_cnt <= '0;
                else if (!act)              hold_cnt <= '0;
                else if (hold_cnt != HOLD_C) hold_cnt <= hold_cnt + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_pend_arb.sv
// Module: irq_pend_arb
// Holds one pending flag per source and picks the winner at an instruction
// boundary. The system-management source has fixed priority.
// Assumes: fire and ack are single-clock-domain. A fire in the same cycle as an
// ack keeps the flag set. Taking a request does not clear it.
module irq_pend_arb
    import irq_rec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  irq_pair_t fire,
    input  irq_pair_t ack,
    input  logic      boundary,
    output irq_pair_t pending,
    output irq_pair_t taken
);

    // Set on fire, clear on ack, new requests merged into the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~ack) | fire;
    end

    // Fixed-priority grant, valid only during the boundary strobe.
    always_comb begin
        taken.smi = boundary & pending.smi;
        taken.nmi = boundary & pending.nmi & ~pending.smi;
    end

endmodule

// File: rtl/irq_edge_recognizer.sv
// Module: irq_edge_recognizer (top)
// Synchronizes and qualifies the non-maskable (active-high, rising edge) and the
// system-management (active-low, falling edge) request lines. Accepted requests
// are latched as pending and reported as taken at instruction boundaries.
// Assumes: rst_n is synchronous to clk. The raw inputs may be fully asynchronous.
module irq_edge_recognizer
    import irq_rec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NMI_QUIET   = 4,
    parameter int NMI_HOLD    = 1,
    parameter int SMI_QUIET   = 2,
    parameter int SMI_HOLD    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_raw,
    input  logic smi_raw_n,
    input  logic insn_boundary,
    input  logic nmi_ack,
    input  logic smi_ack,
    output logic nmi_pending,
    output logic smi_pending,
    output logic nmi_taken,
    output logic smi_taken
);

    logic      nmi_sync;
    logic      smi_sync_n;
    logic      nmi_fire;
    logic      smi_fire;
    irq_pair_t fire_v;
    irq_pair_t ack_v;
    irq_pair_t pend_v;
    irq_pair_t taken_v;

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_nmi_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nmi_raw),
        .sync_out (nmi_sync)
    );

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_smi_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (smi_raw_n),
        .sync_out (smi_sync_n)
    );

    irq_edge_qual #(.POLARITY(POL_HIGH), .QUIET(NMI_QUIET), .HOLD(NMI_HOLD)) u_nmi_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (nmi_sync),
        .fire    (nmi_fire)
    );

    irq_edge_qual #(.POLARITY(POL_LOW), .QUIET(SMI_QUIET), .HOLD(SMI_HOLD)) u_smi_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (smi_sync_n),
        .fire    (smi_fire)
    );

    // Pack per-source signals for the arbiter.
    always_comb begin
        fire_v.nmi = nmi_fire;
        fire_v.smi = smi_fire;
        ack_v.nmi  = nmi_ack;
        ack_v.smi  = smi_ack;
    end

    irq_pend_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire_v),
        .ack      (ack_v),
        .boundary (insn_boundary),
        .pending  (pend_v),
        .taken    (taken_v)
    );

    assign nmi_pending = pend_v.nmi;
    assign smi_pending = pend_v.smi;
    assign nmi_taken   = taken_v.nmi;
    assign smi_taken   = taken_v.smi;

endmodule

// File: rtl/irq_rec_checker.sv
// Module: irq_rec_checker
// Protocol properties of the recognizer. It is bound to the top module and
// observes the ports plus the qualifier fire pulses.
module irq_rec_checker (
    input logic clk,
    input logic rst_n,
    input logic insn_boundary,
    input logic nmi_ack,
    input logic smi_ack,
    input logic nmi_pending,
    input logic smi_pending,
    input logic nmi_taken,
    input logic smi_taken,
    input logic nmi_fire,
    input logic smi_fire
);

    AST_NMI_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_fire |=> !nmi_fire);                                           // R3
    AST_NMI_SET_BY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pending) |-> $past(nmi_fire));                           // R2
    AST_SMI_SET_BY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_pending) |-> $past(smi_fire));                           // R4
    AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_pending) |-> ($past(nmi_ack) || !$past(rst_n)));         // R6
    AST_SMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_pending) |-> ($past(smi_ack) || !$past(rst_n)));         // R6
    AST_NMI_TAKEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_taken |-> (insn_boundary && nmi_pending));                     // R8
    AST_SMI_TAKEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        smi_taken |-> (insn_boundary && smi_pending));                     // R8
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_taken, smi_taken}));                                 // R9
    AST_SMI_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_taken |-> !smi_pending);                                       // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!nmi_pending && !smi_pending));                        // R10

endmodule

bind irq_edge_recognizer irq_rec_checker u_irq_rec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .nmi_ack       (nmi_ack),
    .smi_ack       (smi_ack),
    .nmi_pending   (nmi_pending),
    .smi_pending   (smi_pending),
    .nmi_taken     (nmi_taken),
    .smi_taken     (smi_taken),
    .nmi_fire      (nmi_fire),
    .smi_fire      (smi_fire)
);

// File: tb/test_irq_edge_recognizer.sv
module test_irq_edge_recognizer;

    logic clk = 1'b0;
    logic rst_n;
    logic nmi_raw;
    logic smi_raw_n;
    logic insn_boundary;
    logic nmi_ack;
    logic smi_ack;
    logic nmi_pending;
    logic smi_pending;
    logic nmi_taken;
    logic smi_taken;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irq_edge_recognizer i_irq_edge_recognizer (
        .clk           (clk),
        .rst_n         (rst_n),
        .nmi_raw       (nmi_raw),
        .smi_raw_n     (smi_raw_n),
        .insn_boundary (insn_boundary),
        .nmi_ack       (nmi_ack),
        .smi_ack       (smi_ack),
        .nmi_pending   (nmi_pending),
        .smi_pending   (smi_pending),
        .nmi_taken     (nmi_taken),
        .smi_taken     (smi_taken)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack(input logic nmi, input logic smi);
        nmi_ack = nmi;
        smi_ack = smi;
        idle(1);
        nmi_ack = 1'b0;
        smi_ack = 1'b0;
    endtask

    // Raise the boundary strobe for one cycle and sample the grants inside it.
    task automatic boundary_check(input string req, input logic exp_nmi, input logic exp_smi);
        insn_boundary = 1'b1;
        #1;
        check(req, "nmi_taken at boundary", nmi_taken, exp_nmi);
        check(req, "smi_taken at boundary", smi_taken, exp_smi);
        idle(1);
        insn_boundary = 1'b0;
        #1;
        check("R8", "nmi_taken after boundary", nmi_taken, 1'b0);
        check("R8", "smi_taken after boundary", smi_taken, 1'b0);
    endtask

    task automatic t_reset_state();
        check("R10", "nmi_pending after reset", nmi_pending, 1'b0);
        check("R10", "smi_pending after reset", smi_pending, 1'b0);
        boundary_check("R10", 1'b0, 1'b0);
    endtask

    task automatic t_nmi_basic();
        idle(6);
        nmi_raw = 1'b1;
        idle(2);
        check("R1", "nmi_pending two edges after rise", nmi_pending, 1'b0);
        idle(1);
        check("R1", "nmi_pending three edges after rise", nmi_pending, 1'b1);
        boundary_check("R8", 1'b1, 1'b0);
        idle(3);
        check("R6", "nmi_pending kept after taken", nmi_pending, 1'b1);
        pulse_ack(1'b1, 1'b0);
        check("R6", "nmi_pending cleared by ack", nmi_pending, 1'b0);
    endtask

    task automatic t_nmi_level();
        idle(8);
        check("R3", "held high does not retrigger", nmi_pending, 1'b0);
    endtask

    task automatic t_nmi_quiet();
        nmi_raw = 1'b0;
        idle(3);
        nmi_raw = 1'b1;
        idle(5);
        check("R2", "rise after 3 low clocks rejected", nmi_pending, 1'b0);
        nmi_raw = 1'b0;
        idle(4);
        nmi_raw = 1'b1;
        idle(3);
        check("R2", "rise after 4 low clocks accepted", nmi_pending, 1'b1);
        pulse_ack(1'b1, 1'b0);
        nmi_raw = 1'b0;
        idle(6);
    endtask

    task automatic t_smi_basic();
        smi_raw_n = 1'b0;
        idle(3);
        check("R4", "smi_pending three edges after fall", smi_pending, 1'b0);
        idle(1);
        check("R4", "smi_pending four edges after fall", smi_pending, 1'b1);
        boundary_check("R4", 1'b0, 1'b1);
        pulse_ack(1'b0, 1'b1);
        check("R6", "smi_pending cleared by ack", smi_pending, 1'b0);
        smi_raw_n = 1'b1;
        idle(5);
    endtask

    task automatic t_smi_reject();
        smi_raw_n = 1'b0;
        idle(1);
        smi_raw_n = 1'b1;
        idle(6);
        check("R5", "one-clock low pulse ignored", smi_pending, 1'b0);
        smi_raw_n = 1'b0;
        idle(1);
        smi_raw_n = 1'b1;
        idle(1);
        smi_raw_n = 1'b0;
        idle(7);
        check("R5", "fall after one high clock ignored", smi_pending, 1'b0);
        smi_raw_n = 1'b1;
        idle(5);
    endtask

    task automatic t_priority();
        nmi_raw   = 1'b1;
        smi_raw_n = 1'b0;
        idle(5);
        check("R9", "nmi pending before grant", nmi_pending, 1'b1);
        check("R9", "smi pending before grant", smi_pending, 1'b1);
        boundary_check("R9", 1'b0, 1'b1);
        check("R9", "nmi still pending after losing", nmi_pending, 1'b1);
        pulse_ack(1'b0, 1'b1);
        idle(1);
        boundary_check("R9", 1'b1, 1'b0);
        pulse_ack(1'b1, 1'b0);
        nmi_raw   = 1'b0;
        smi_raw_n = 1'b1;
        idle(6);
    endtask

    task automatic t_merge();
        nmi_raw = 1'b1;
        idle(4);
        #1;
        check("R8", "no grant without boundary", nmi_taken, 1'b0);
        idle(1);
        nmi_raw = 1'b0;
        idle(5);
        nmi_raw = 1'b1;
        idle(4);
        check("R7", "pending after second edge", nmi_pending, 1'b1);
        pulse_ack(1'b1, 1'b0);
        check("R7", "single ack clears merged flag", nmi_pending, 1'b0);
        idle(4);
        check("R7", "no queued second request", nmi_pending, 1'b0);
        nmi_raw = 1'b0;
        idle(6);
    endtask

    task automatic t_reset_clear();
        nmi_raw   = 1'b1;
        smi_raw_n = 1'b0;
        idle(5);
        check("R10", "nmi pending before reset", nmi_pending, 1'b1);
        rst_n = 1'b0;
        idle(1);
        check("R10", "reset clears nmi_pending", nmi_pending, 1'b0);
        check("R10", "reset clears smi_pending", smi_pending, 1'b0);
        rst_n     = 1'b1;
        nmi_raw   = 1'b0;
        smi_raw_n = 1'b1;
        idle(6);
        check("R10", "nmi stays clear after reset", nmi_pending, 1'b0);
        check("R10", "smi stays clear after reset", smi_pending, 1'b0);
    endtask

    initial begin
        rst_n         = 1'b0;
        nmi_raw       = 1'b0;
        smi_raw_n     = 1'b1;
        insn_boundary = 1'b0;
        nmi_ack       = 1'b0;
        smi_ack       = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_state();
        t_nmi_basic();
        t_nmi_level();
        t_nmi_quiet();
        t_smi_basic();
        t_smi_reject();
        t_priority();
        t_merge();
        t_reset_clear();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule